// File: doc/BRIEF.md
# Coarse-grained hardware thread fetch scheduler

This block decides which of several hardware thread contexts feeds the next instruction fetch of a single-issue, in-order pipeline. It holds one program counter and one run state (idle, ready, waiting) per thread. The thread that owns the fetch stream keeps it until the pipeline reports a hazard for it that forwarding cannot cover. The thread's counter is then rewound to the stalled instruction, and the fetch in the very next cycle comes from another ready thread, picked round-robin. No bubble cycle is spent on the switch.

Threads never take interrupts. A thread parks itself with a control-register write that names one of the external event lines, and it becomes ready again when that line fires. An event that fires with nobody waiting is remembered as pending, so a later wait on it returns at once. Software starts idle threads with a second control-register operation that supplies the start address.

The fetch side is a valid/ready stream. `fetch_valid` is high whenever a thread owns the stream. A transfer happens on a clock edge where `fetch_valid` and `fetch_ready` are both high, and the owning thread's counter then moves on by 4. While `fetch_valid` is high and `fetch_ready` is low, `fetch_tid` and `fetch_pc` hold. Only a hazard, a redirect or a wait aimed at the owning thread can change them during a stall. Hazard, redirect, control-register and event inputs are single-cycle pulses without back-pressure.

Top module: `mt_fetch_sched`

## Requirements
- R1: Out of reset only thread 0 is ready: `fetch_valid`=1, `fetch_tid`=0, `fetch_pc`=RESET_PC. Threads 1..NTHR-1 are idle and are never fetched until they are started.
- R2: Each fetch transfer adds 4 to the owning thread's counter. While `fetch_valid`=1 and `fetch_ready`=0, with no hazard, redirect or wait on the owning thread, `fetch_tid` and `fetch_pc` stay unchanged.
- R3: A hazard (`hz_valid`) on the owning thread moves ownership, in the next cycle, to the first ready thread in the order owner+1, owner+2, … with wrap-around. The owner itself comes last in that order. No idle cycle is inserted when some thread is ready.
- R4: A hazard sets that thread's counter to `hz_pc`, so the thread refetches that address when it next owns the stream.
- R5: A redirect (`rd_valid`) sets the counter of thread `rd_tid` to `rd_pc` without a switch. For one thread, a hazard has priority over a redirect, and a redirect has priority over the +4 advance.
- R6: A control-register write with `csr_op`=1 (start) makes thread `csr_target` ready at address `csr_wdata`, but only if that thread is idle. Otherwise the write has no effect.
- R7: A write with `csr_op`=0 (wait) from ready thread `csr_tid` names event line `csr_wdata[EVW-1:0]` and sets the thread's resume address to `csr_pc`. Unless that event is pending or firing in the same cycle, the thread stops being fetched and ownership moves as in R3.
- R8: A waiting thread becomes ready in the cycle after its event line is high, and it resumes at its resume address when it is next picked.
- R9: An event line that is high while no thread waits on it becomes pending. A wait on a pending event completes at once: the thread stays ready, its counter becomes `csr_pc`, and the pending flag is cleared.
- R10: With no thread ready, `fetch_valid` is 0. When threads become ready again, the first ready one after the last owner, in the order of R3, takes the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | output | 1 | A thread owns the fetch stream |
| fetch_ready | input | 1 | Fetch stage accepts the current address |
| fetch_tid | output | TID_W | Owning thread |
| fetch_pc | output | PC_W | Address to fetch |
| hz_valid | input | 1 | Unresolvable hazard report |
| hz_tid | input | TID_W | Thread of the stalled instruction |
| hz_pc | input | PC_W | Address of the stalled instruction |
| rd_valid | input | 1 | Control-flow redirect |
| rd_tid | input | TID_W | Thread being redirected |
| rd_pc | input | PC_W | Redirect target |
| csr_we | input | 1 | Scheduler control-register write |
| csr_op | input | 1 | 0 = wait, 1 = start |
| csr_tid | input | TID_W | Thread issuing the write |
| csr_pc | input | PC_W | Resume address for a wait |
| csr_wdata | input | PC_W | Event index (wait) or start address (start) |
| csr_target | input | TID_W | Thread to start |
| evt_in | input | NEVT | External event lines |

## Verification
The bench runs a fixed script of hazards across three started threads, so each switch shows whether the round-robin search really begins after the owner and skips idle and waiting threads. The rewound addresses show that each thread comes back to its own stalled instruction. A wait is tried in three ways: against an event that fires later, against one that fired earlier with no waiter, and a second time against the same event. The second wait must block, which shows the pending flag was cleared. Finally every thread is parked to empty the ready set, two events fire together to show which thread wins, and short patterns cover a redirect, a start aimed at a busy thread, and a held `fetch_ready`.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_READY = 2'd1,
    TS_WAIT  = 2'd2
  } ts_e;

  localparam logic OP_WAIT  = 1'b0;
  localparam logic OP_START = 1'b1;

endpackage

// File: rtl/mt_thread_ctx.sv
module mt_thread_ctx
  import mt_sched_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          EVW      = 3,
  parameter int          THR_ID   = 0,
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wait_req,
  input  logic            wait_imm,
  input  logic [EVW-1:0]  wait_evt,
  input  logic [PC_W-1:0] resume_pc,
  input  logic            hz_hit,
  input  logic [PC_W-1:0] hz_pc,
  input  logic            rd_hit,
  input  logic [PC_W-1:0] rd_pc,
  input  logic            start_req,
  input  logic [PC_W-1:0] start_pc,
  input  logic            wake,
  input  logic            adv,
  output ts_e             state_o,
  output logic [PC_W-1:0] pc_o,
  output logic [EVW-1:0]  evt_o,
  output logic            ready_nxt
);

  localparam ts_e             RST_ST = (THR_ID == 0) ? TS_READY : TS_IDLE;
  localparam logic [PC_W-1:0] RST_PC = (THR_ID == 0) ? PC_W'(RESET_PC) : '0;

  ts_e            st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [EVW-1:0]  evt_q, evt_d;

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    evt_d = evt_q;
    unique case (st_q)
      TS_IDLE: begin
        if (start_req) begin
          st_d = TS_READY;
          pc_d = start_pc;
        end
      end
      TS_WAIT: begin
        if (wake) st_d = TS_READY;
      end
      TS_READY: begin
        if (wait_req) begin
          pc_d = resume_pc;
          if (!wait_imm) begin
            st_d  = TS_WAIT;
            evt_d = wait_evt;
          end
        end else if (hz_hit) begin
          pc_d = hz_pc;
        end else if (rd_hit) begin
          pc_d = rd_pc;
        end else if (adv) begin
          pc_d = pc_q + PC_W'(4);
        end
      end
      default: st_d = TS_IDLE;
    endcase
  end

  assign ready_nxt = (st_d == TS_READY);
  assign state_o   = st_q;
  assign pc_o      = pc_q;
  assign evt_o     = evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= RST_ST;
      pc_q  <= RST_PC;
      evt_q <= '0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      evt_q <= evt_d;
    end
  end

  AST_HZ_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_READY && hz_hit && !wait_req) |=> (pc_q == $past(hz_pc))); // R4

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_IDLE && !start_req) |=> (st_q == TS_IDLE)); // R1

  AST_BUSY_START_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_WAIT && start_req && !wake) |=> (st_q == TS_WAIT && $stable(pc_q))); // R6

  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_READY && wait_req && !wait_imm) |=> (st_q == TS_WAIT && pc_q == $past(resume_pc))); // R7

endmodule

// File: rtl/mt_event_unit.sv
module mt_event_unit #(
  parameter int NTHR = 4,
  parameter int NEVT = 8,
  localparam int EVW = $clog2(NEVT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NEVT-1:0]           evt_in,
  input  logic [NTHR-1:0]           waiting,
  input  logic [NTHR-1:0][EVW-1:0]  wevt,
  input  logic                      wait_req,
  input  logic [EVW-1:0]            wait_evt,
  output logic [NTHR-1:0]           wake,
  output logic                      wait_imm
);

  logic [NEVT-1:0] pend_q, pend_d;
  logic [NEVT-1:0] waited;

  always_comb begin
    waited   = '0;
    wake     = '0;
    wait_imm = 1'b0;
    pend_d   = pend_q;
    for (int t = 0; t < NTHR; t++) begin
      for (int e = 0; e < NEVT; e++) begin
        if (waiting[t] && wevt[t] == EVW'(e)) begin
          waited[e] = 1'b1;
          if (evt_in[e]) wake[t] = 1'b1;
        end
      end
    end
    for (int e = 0; e < NEVT; e++) begin
      if (wait_req && wait_evt == EVW'(e)) begin
        wait_imm  = pend_q[e] | evt_in[e];
        pend_d[e] = 1'b0;
      end else if (evt_in[e] && !waited[e]) begin
        pend_d[e] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && wait_imm) |=> !pend_q[$past(wait_evt)]); // R9

  AST_WAKE_NEEDS_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake) |-> (|(waiting & wake))); // R8

endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int NTHR = 4,
  localparam int TID_W = $clog2(NTHR)
) (
  input  logic [TID_W-1:0] cur,
  input  logic             keep,
  input  logic [NTHR-1:0]  ready,
  output logic [TID_W-1:0] nxt,
  output logic             nxt_valid
);

  always_comb begin
    logic [TID_W-1:0] idx;
    nxt       = cur;
    nxt_valid = keep;
    idx       = '0;
    if (!keep) begin
      for (int k = 1; k <= NTHR; k++) begin
        idx = TID_W'((int'(cur) + k) % NTHR);
        if (!nxt_valid && ready[idx]) begin
          nxt       = idx;
          nxt_valid = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mt_fetch_sched.sv
module mt_fetch_sched
  import mt_sched_pkg::*;
#(
  parameter int          NTHR     = 4,
  parameter int          PC_W     = 32,
  parameter int          NEVT     = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  localparam int         TID_W    = $clog2(NTHR),
  localparam int         EVW      = $clog2(NEVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [TID_W-1:0] fetch_tid,
  output logic [PC_W-1:0]  fetch_pc,
  input  logic             hz_valid,
  input  logic [TID_W-1:0] hz_tid,
  input  logic [PC_W-1:0]  hz_pc,
  input  logic             rd_valid,
  input  logic [TID_W-1:0] rd_tid,
  input  logic [PC_W-1:0]  rd_pc,
  input  logic             csr_we,
  input  logic             csr_op,
  input  logic [TID_W-1:0] csr_tid,
  input  logic [PC_W-1:0]  csr_pc,
  input  logic [PC_W-1:0]  csr_wdata,
  input  logic [TID_W-1:0] csr_target,
  input  logic [NEVT-1:0]  evt_in
);

  ts_e                      st_arr [NTHR];
  logic [PC_W-1:0]          pc_arr [NTHR];
  logic [NTHR-1:0][EVW-1:0] evt_arr;
  logic [NTHR-1:0]          ready_nxt, waiting, wake, wait_vec;
  logic                     wait_imm;
  logic [TID_W-1:0]         cur_q, nxt;
  logic                     curv_q, nxt_valid, keep;
  logic                     hz_on_cur, rd_on_cur, wait_on_cur, xfer;
  logic [EVW-1:0]           wait_evt;

  assign xfer        = curv_q && fetch_ready;
  assign hz_on_cur   = hz_valid && hz_tid == cur_q;
  assign rd_on_cur   = rd_valid && rd_tid == cur_q;
  assign wait_on_cur = wait_vec[cur_q];
  assign wait_evt    = csr_wdata[EVW-1:0];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic hz_hit, rd_hit, start_req, adv;
    assign hz_hit      = hz_valid && hz_tid == TID_W'(t);
    assign rd_hit      = rd_valid && rd_tid == TID_W'(t);
    assign start_req   = csr_we && csr_op == OP_START && csr_target == TID_W'(t);
    assign wait_vec[t] = csr_we && csr_op == OP_WAIT && csr_tid == TID_W'(t)
                         && st_arr[t] == TS_READY;
    assign adv         = xfer && cur_q == TID_W'(t);
    assign waiting[t]  = (st_arr[t] == TS_WAIT);

    mt_thread_ctx #(
      .PC_W     (PC_W),
      .EVW      (EVW),
      .THR_ID   (t),
      .RESET_PC (RESET_PC)
    ) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_req  (wait_vec[t]),
      .wait_imm  (wait_imm),
      .wait_evt  (wait_evt),
      .resume_pc (csr_pc),
      .hz_hit    (hz_hit),
      .hz_pc     (hz_pc),
      .rd_hit    (rd_hit),
      .rd_pc     (rd_pc),
      .start_req (start_req),
      .start_pc  (csr_wdata),
      .wake      (wake[t]),
      .adv       (adv),
      .state_o   (st_arr[t]),
      .pc_o      (pc_arr[t]),
      .evt_o     (evt_arr[t]),
      .ready_nxt (ready_nxt[t])
    );
  end

  mt_event_unit #(
    .NTHR (NTHR),
    .NEVT (NEVT)
  ) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_in),
    .waiting  (waiting),
    .wevt     (evt_arr),
    .wait_req (|wait_vec),
    .wait_evt (wait_evt),
    .wake     (wake),
    .wait_imm (wait_imm)
  );

  assign keep = curv_q && ready_nxt[cur_q] && !hz_on_cur;

  mt_rr_pick #(
    .NTHR (NTHR)
  ) u_pick (
    .cur       (cur_q),
    .keep      (keep),
    .ready     (ready_nxt),
    .nxt       (nxt),
    .nxt_valid (nxt_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      curv_q <= 1'b1;
    end else begin
      curv_q <= nxt_valid;
      if (nxt_valid) cur_q <= nxt;
    end
  end

  assign fetch_valid = curv_q;
  assign fetch_tid   = cur_q;
  assign fetch_pc    = pc_arr[cur_q];

  logic [NTHR-1:0] others_ready;
  always_comb begin
    others_ready = ready_nxt;
    others_ready[cur_q] = 1'b0;
  end

  AST_OWNER_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (st_arr[fetch_tid] == TS_READY)); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !hz_on_cur && !rd_on_cur && !wait_on_cur)
    |=> (fetch_valid && $stable(fetch_tid) && $stable(fetch_pc))); // R2

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && hz_on_cur && (|ready_nxt)) |=> fetch_valid); // R3

  AST_SWITCH_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && hz_on_cur && (|others_ready)) |=> (fetch_tid != $past(fetch_tid))); // R3

  AST_REDIRECT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && rd_on_cur && !hz_valid && !wait_on_cur)
    |=> (fetch_valid && fetch_tid == $past(fetch_tid) && fetch_pc == $past(rd_pc))); // R5

endmodule

// File: tb/mt_fetch_sched_bench.sv
module mt_fetch_sched_bench;

  localparam int NTHR = 4;
  localparam int PC_W = 32;
  localparam int NEVT = 8;

  typedef struct {
    int          tid;
    logic [31:0] pc;
    string       req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fetch_valid;
  logic             fetch_ready = 1'b0;
  logic [1:0]       fetch_tid;
  logic [PC_W-1:0]  fetch_pc;
  logic             hz_valid = 1'b0;
  logic [1:0]       hz_tid = '0;
  logic [PC_W-1:0]  hz_pc = '0;
  logic             rd_valid = 1'b0;
  logic [1:0]       rd_tid = '0;
  logic [PC_W-1:0]  rd_pc = '0;
  logic             csr_we = 1'b0;
  logic             csr_op = 1'b0;
  logic [1:0]       csr_tid = '0;
  logic [PC_W-1:0]  csr_pc = '0;
  logic [PC_W-1:0]  csr_wdata = '0;
  logic [1:0]       csr_target = '0;
  logic [NEVT-1:0]  evt_in = '0;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  mt_fetch_sched #(
    .NTHR (NTHR), .PC_W (PC_W), .NEVT (NEVT), .RESET_PC (32'h100)
  ) u_mt_fetch_sched (
    .clk (clk), .rst_n (rst_n),
    .fetch_valid (fetch_valid), .fetch_ready (fetch_ready),
    .fetch_tid (fetch_tid), .fetch_pc (fetch_pc),
    .hz_valid (hz_valid), .hz_tid (hz_tid), .hz_pc (hz_pc),
    .rd_valid (rd_valid), .rd_tid (rd_tid), .rd_pc (rd_pc),
    .csr_we (csr_we), .csr_op (csr_op), .csr_tid (csr_tid),
    .csr_pc (csr_pc), .csr_wdata (csr_wdata), .csr_target (csr_target),
    .evt_in (evt_in)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input int tid, input logic [31:0] pc, input string req);
    exp_t e;
    e.tid = tid; e.pc = pc; e.req = req;
    exp_q.push_back(e);
  endtask

  // one slot = one clock period; inputs change 1 time unit after the falling edge
  task automatic next_slot();
    @(negedge clk); #1;
    hz_valid = 1'b0; rd_valid = 1'b0; csr_we = 1'b0; evt_in = '0;
  endtask

  task automatic do_hz(input int t, input logic [31:0] pc);
    next_slot(); hz_valid = 1'b1; hz_tid = 2'(t); hz_pc = pc;
  endtask

  task automatic do_start(input int t, input logic [31:0] pc);
    next_slot(); csr_we = 1'b1; csr_op = 1'b1; csr_target = 2'(t); csr_wdata = pc;
  endtask

  task automatic do_wait(input int t, input int ev, input logic [31:0] rpc);
    next_slot(); csr_we = 1'b1; csr_op = 1'b0; csr_tid = 2'(t);
    csr_wdata = 32'(ev); csr_pc = rpc;
  endtask

  // monitor: compare every fetch transfer against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && fetch_valid && fetch_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected transfer", longint'(fetch_pc), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(fetch_tid) == e.tid, e.req, longint'(fetch_tid), longint'(e.tid));
          check(fetch_pc == e.pc, e.req, longint'(fetch_pc), longint'(e.pc));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    push(0, 32'h100, "R1"); push(0, 32'h104, "R2"); push(0, 32'h108, "R6");
    push(0, 32'h10C, "R2"); push(0, 32'h110, "R2"); push(1, 32'h200, "R3");
    push(1, 32'h204, "R6"); push(2, 32'h300, "R3"); push(2, 32'h304, "R3");
    push(0, 32'h108, "R4"); push(0, 32'h10C, "R4"); push(1, 32'h204, "R4");
    push(1, 32'h208, "R4"); push(2, 32'h300, "R7"); push(2, 32'h304, "R7");
    push(2, 32'h308, "R7"); push(2, 32'h30C, "R8"); push(0, 32'h10C, "R3");
    push(1, 32'h20C, "R8"); push(1, 32'h210, "R9"); push(1, 32'h214, "R9");
    push(2, 32'h30C, "R9"); push(0, 32'h10C, "R7"); push(2, 32'h310, "R10");
    push(0, 32'h110, "R10"); push(0, 32'h400, "R5"); push(0, 32'h404, "R5");
    push(0, 32'h408, "R5"); push(2, 32'h310, "R6"); push(2, 32'h314, "R2");
    push(2, 32'h318, "R2");

    repeat (3) @(negedge clk);
    #1;
    check(fetch_valid == 1'b1, "R1 reset valid", longint'(fetch_valid), 1);
    check(fetch_tid == 2'd0, "R1 reset tid", longint'(fetch_tid), 0);
    check(fetch_pc == 32'h100, "R1 reset pc", longint'(fetch_pc), 32'h100);

    next_slot(); rst_n = 1'b1; fetch_ready = 1'b1;        // s0
    do_start(1, 32'h200);                                  // s1
    do_start(2, 32'h300);                                  // s2
    next_slot();                                           // s3
    do_hz(0, 32'h108);                                     // s4
    next_slot();                                           // s5
    do_hz(1, 32'h204);                                     // s6
    next_slot();                                           // s7
    do_hz(2, 32'h300);                                     // s8
    next_slot();                                           // s9
    do_hz(0, 32'h10C);                                     // s10
    next_slot();                                           // s11
    do_wait(1, 3, 32'h20C);                                // s12 R7
    next_slot(); next_slot();                              // s13 s14
    next_slot(); evt_in = 8'(1 << 3);                      // s15 R8
    do_hz(2, 32'h30C);                                     // s16
    do_hz(0, 32'h10C);                                     // s17
    next_slot(); evt_in = 8'(1 << 5);                      // s18 R9 pending
    do_wait(1, 5, 32'h214);                                // s19 immediate
    do_wait(1, 5, 32'h218);                                // s20 blocks
    do_wait(2, 1, 32'h310);                                // s21
    do_wait(0, 2, 32'h110);                                // s22 nobody ready
    next_slot();                                           // s23
    check(fetch_valid == 1'b0, "R10 idle stream", longint'(fetch_valid), 0);
    next_slot();                                           // s24
    check(fetch_valid == 1'b0, "R10 idle stream", longint'(fetch_valid), 0);
    next_slot(); evt_in = 8'((1 << 1) | (1 << 2));         // s25
    do_hz(2, 32'h310);                                     // s26
    next_slot(); rd_valid = 1'b1; rd_tid = 2'd0; rd_pc = 32'h400; // s27 R5
    next_slot();                                           // s28
    do_start(2, 32'h9990);                                 // s29 R6 ignored
    do_hz(0, 32'h408);                                     // s30
    next_slot();                                           // s31
    next_slot(); fetch_ready = 1'b0;                       // s32
    next_slot();                                           // s33
    check(fetch_valid && fetch_tid == 2'd2, "R2 stall tid", longint'(fetch_tid), 2);
    check(fetch_pc == 32'h314, "R2 stall pc", longint'(fetch_pc), 32'h314);
    next_slot(); fetch_ready = 1'b1;                       // s34
    next_slot();                                           // s35
    next_slot(); fetch_ready = 1'b0;                       // s36
    repeat (3) next_slot();
    check(exp_q.size() == 0, "R2 missing transfers", longint'(exp_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule